// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Pattern Generator

This block turns a system clock into the four gate commands of a full bridge. A period counter forms a digital ramp. Each time the ramp reaches its end value, an oscillator tick occurs. Half-bridge A/B changes state on every tick, so each of its outputs runs near 50% duty at half the tick rate. Half-bridge C/D has the same square-wave behaviour. It changes state when the ramp equals a phase command, which makes its lag behind A/B the controlled quantity. The pulse width stays fixed.

The two legs have separate dead-time counters. Each counter length comes from a per-leg base value that is shortened as a load code (the sensed current) rises above an adaptive offset code. The shortening reaches a 4:1 ratio at a peak code. A bypass input removes dead time altogether. A no-load comparator with hysteresis acts on the error/duty code, and a force-off input also acts on the outputs. Either one pulls all four outputs low on the next clock edge. The period and phase counters keep running, so the bridge restarts in step when the outputs are released.

Top module: `psfb_pwm`

## Requirements
- R1: During reset and after it, all four gate outputs are low. The ramp restarts at 0 with period RST_PERIOD and phase RST_PHASE. The no-load comparator starts in the off state, so the outputs stay low until the error code first exceeds NL_ON.
- R2: The ramp counts 0..P, where P is the active period register, and a tick occurs on the edge where the ramp equals P. Leg A/B changes state on every tick, so each leg period is 2×(P+1) clocks. `period_in` is copied into P only on a tick.
- R3: Leg C/D changes state on the edge where the ramp equals the active phase register, clamped to P. `phase_in` is copied into the phase register only on a tick. A phase equal to P makes both legs switch on the same edge.
- R4: The two outputs of one leg are never high together. The outgoing output falls on the switching edge. The incoming output rises D clocks later, where D is that leg's dead time, so both outputs are low for D clocks.
- R5: The dead time of a leg is D = floor(base×PEAK / (PEAK + 3×s)), with s = min(max(cs − ads, 0), PEAK) and PEAK = PEAK_CODE. The value is computed from base, cs and ads as sampled one clock earlier. A/B uses `dt_ab_base` and C/D uses `dt_cd_base`.
- R6: When ads equals cs, or ads exceeds cs, the dead time equals the base value, with no modulation.
- R7: With `dt_bypass` high, D is 0 and the incoming output rises on the switching edge itself.
- R8: D is captured once at each switching edge. Later changes to cs, ads or base do not lengthen or shorten an interval already running.
- R9: The no-load comparator turns off when the error code is below NL_OFF. It turns on when the code is above NL_ON. Between the two thresholds it keeps its state. Its new state acts on the outputs on the same edge where it changes.
- R10: When `force_off` is high at an edge, all four outputs are low after that edge. When it is released, the outputs follow the leg state and dead-time counters, which keep running throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | CNT_W | Ramp end value, taken on a tick |
| phase_in | input | CNT_W | Ramp value at which leg C/D switches, taken on a tick |
| err_code | input | CODE_W | Error/duty code fed to the no-load comparator |
| cs_code | input | CODE_W | Load current code |
| ads_code | input | CODE_W | Adaptive offset subtracted from the load code |
| dt_ab_base | input | DT_W | Unmodulated dead time of leg A/B, in clocks |
| dt_cd_base | input | DT_W | Unmodulated dead time of leg C/D, in clocks |
| dt_bypass | input | 1 | Removes dead time on both legs |
| force_off | input | 1 | Drives all outputs low from the next edge |
| gate_a | output | 1 | Leg A/B high-side command |
| gate_b | output | 1 | Leg A/B low-side command |
| gate_c | output | 1 | Leg C/D high-side command |
| gate_d | output | 1 | Leg C/D low-side command |

## Verification
The collision that matters most is a leg switching edge on the same edge as a shutdown. The shutdown can come from `force_off` or from the no-load comparator crossing a threshold. In that case the leg state and its dead-time counter must still advance while the outputs stay low, so that release lands in the correct place of the pattern. The bench provokes this with short random `force_off` pulses and error codes that hover around both thresholds, while the phase register sometimes equals the period so that both legs switch together. A per-cycle reference model, built from the requirements, judges every output on every clock.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  localparam int unsigned NUM_LEGS = 2;

  typedef enum logic [0:0] {
    LEG_AB = 1'b0,
    LEG_CD = 1'b1
  } leg_id_e;

  // multiplier applied to the saturated load difference in the dead-time divisor
  localparam int unsigned DT_SLOPE = 3;

endpackage

// File: rtl/psfb_osc.sv
module psfb_osc #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned RST_PERIOD = 99,
  parameter int unsigned RST_PHASE  = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] phase_in,
  output logic             tick,
  output logic             ph_hit
);

  logic [CNT_W-1:0] ramp_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] ph_q;
  logic [CNT_W-1:0] ph_eff;

  assign ph_eff = (ph_q > per_q) ? per_q : ph_q;
  assign tick   = (ramp_q == per_q);
  assign ph_hit = (ramp_q == ph_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= '0;
      per_q  <= CNT_W'(RST_PERIOD);
      ph_q   <= CNT_W'(RST_PHASE);
    end else if (tick) begin
      ramp_q <= '0;
      per_q  <= period_in;
      ph_q   <= phase_in;
    end else begin
      ramp_q <= ramp_q + CNT_W'(1);
    end
  end

  // R2
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(per_q));

  // R2
  ramp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_q <= per_q);

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ph_q));

endmodule

// File: rtl/psfb_deadcalc.sv
module psfb_deadcalc #(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned DT_W      = 8,
  parameter int unsigned PEAK_CODE = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DT_W-1:0]   base,
  input  logic [CODE_W-1:0] cs,
  input  logic [CODE_W-1:0] ads,
  input  logic              bypass,
  output logic [DT_W-1:0]   dt_q
);

  import psfb_pkg::*;

  localparam int unsigned PROD_W = DT_W + CODE_W + 3;
  localparam logic [CODE_W-1:0] PEAK_C = CODE_W'(PEAK_CODE);

  logic [CODE_W-1:0] diff;
  logic [CODE_W-1:0] sat;
  logic [PROD_W-1:0] num;
  logic [PROD_W-1:0] den;
  logic [DT_W-1:0]   quo;

  always_comb begin
    diff = (cs > ads) ? (cs - ads) : '0;
    sat  = (diff > PEAK_C) ? PEAK_C : diff;
    num  = PROD_W'(base) * PROD_W'(PEAK_CODE);
    den  = PROD_W'(PEAK_CODE) + PROD_W'(sat) * PROD_W'(DT_SLOPE);
    quo  = DT_W'(num / den);
  end

  always_ff @(posedge clk) begin
    if (rst)         dt_q <= '0;
    else if (bypass) dt_q <= '0;
    else             dt_q <= quo;
  end

  // R6
  no_modulation_chk: assert property (@(posedge clk) disable iff (rst)
    (cs == ads && !bypass) |=> (dt_q == $past(base)));

  // R7
  bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (dt_q == '0));

  // R5
  never_longer_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dt_q <= $past(base)));

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flip,
  input  logic [DT_W-1:0] dt_len,
  input  logic            en,
  output logic            hi_q,
  output logic            lo_q
);

  logic            side_q;
  logic [DT_W-1:0] dtc_q;
  logic            side_n;
  logic [DT_W-1:0] dtc_n;
  logic            idle_n;

  always_comb begin
    if (flip) begin
      side_n = ~side_q;
      dtc_n  = dt_len;
    end else begin
      side_n = side_q;
      dtc_n  = (dtc_q != '0) ? (dtc_q - DT_W'(1)) : '0;
    end
    idle_n = (dtc_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= 1'b0;
      dtc_q  <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      side_q <= side_n;
      dtc_q  <= dtc_n;
      hi_q   <= en & side_n & idle_n;
      lo_q   <= en & ~side_n & idle_n;
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));

  // R4
  gap_start_chk: assert property (@(posedge clk) disable iff (rst)
    (flip && dt_len != '0) |=> (!hi_q && !lo_q));

  // R8
  gap_count_chk: assert property (@(posedge clk) disable iff (rst)
    (dtc_q != '0 && !flip) |=> (dtc_q == $past(dtc_q) - DT_W'(1)));

endmodule

// File: rtl/psfb_noload.sv
module psfb_noload #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned NL_OFF = 64,
  parameter int unsigned NL_ON  = 77
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] err,
  output logic              run_n
);

  logic run_q;

  assign run_n = run_q ? !(err < CODE_W'(NL_OFF)) : (err > CODE_W'(NL_ON));

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_n;
  end

  // R9
  low_turns_off_chk: assert property (@(posedge clk) disable iff (rst)
    (err < CODE_W'(NL_OFF)) |=> !run_q);

  // R9
  high_turns_on_chk: assert property (@(posedge clk) disable iff (rst)
    (err > CODE_W'(NL_ON)) |=> run_q);

  // R9
  band_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (!(err < CODE_W'(NL_OFF)) && !(err > CODE_W'(NL_ON))) |=> (run_q == $past(run_q)));

endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned DT_W       = 8,
  parameter int unsigned PEAK_CODE  = 128,
  parameter int unsigned NL_OFF     = 64,
  parameter int unsigned NL_ON      = 77,
  parameter int unsigned RST_PERIOD = 99,
  parameter int unsigned RST_PHASE  = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  period_in,
  input  logic [CNT_W-1:0]  phase_in,
  input  logic [CODE_W-1:0] err_code,
  input  logic [CODE_W-1:0] cs_code,
  input  logic [CODE_W-1:0] ads_code,
  input  logic [DT_W-1:0]   dt_ab_base,
  input  logic [DT_W-1:0]   dt_cd_base,
  input  logic              dt_bypass,
  input  logic              force_off,
  output logic              gate_a,
  output logic              gate_b,
  output logic              gate_c,
  output logic              gate_d
);

  import psfb_pkg::*;

  logic                tick;
  logic                ph_hit;
  logic                run_n;
  logic                gate_en;
  logic [NUM_LEGS-1:0] flip_v;
  logic [NUM_LEGS-1:0] hi_v;
  logic [NUM_LEGS-1:0] lo_v;
  logic [DT_W-1:0]     base_arr [NUM_LEGS];

  psfb_osc #(
    .CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD), .RST_PHASE(RST_PHASE)
  ) i_osc (
    .clk(clk), .rst(rst), .period_in(period_in), .phase_in(phase_in),
    .tick(tick), .ph_hit(ph_hit)
  );

  psfb_noload #(
    .CODE_W(CODE_W), .NL_OFF(NL_OFF), .NL_ON(NL_ON)
  ) i_noload (
    .clk(clk), .rst(rst), .err(err_code), .run_n(run_n)
  );

  assign gate_en        = ~force_off & run_n;
  assign flip_v[LEG_AB] = tick;
  assign flip_v[LEG_CD] = ph_hit;
  assign base_arr[LEG_AB] = dt_ab_base;
  assign base_arr[LEG_CD] = dt_cd_base;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    logic [DT_W-1:0] dt_len;

    psfb_deadcalc #(
      .CODE_W(CODE_W), .DT_W(DT_W), .PEAK_CODE(PEAK_CODE)
    ) i_deadcalc (
      .clk(clk), .rst(rst), .base(base_arr[g]), .cs(cs_code), .ads(ads_code),
      .bypass(dt_bypass), .dt_q(dt_len)
    );

    psfb_leg #(
      .DT_W(DT_W)
    ) i_leg (
      .clk(clk), .rst(rst), .flip(flip_v[g]), .dt_len(dt_len), .en(gate_en),
      .hi_q(hi_v[g]), .lo_q(lo_v[g])
    );
  end

  assign gate_a = hi_v[LEG_AB];
  assign gate_b = lo_v[LEG_AB];
  assign gate_c = hi_v[LEG_CD];
  assign gate_d = lo_v[LEG_CD];

  // R10
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !(gate_a || gate_b || gate_c || gate_d));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> !(gate_a || gate_b || gate_c || gate_d));

endmodule

// File: tb/test_psfb_pwm.sv
module test_psfb_pwm;

  localparam int CNT_W      = 10;
  localparam int CODE_W     = 8;
  localparam int DT_W       = 8;
  localparam int PEAK       = 128;
  localparam int NL_OFF     = 64;
  localparam int NL_ON      = 77;
  localparam int RST_PERIOD = 99;
  localparam int RST_PHASE  = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0]  period_in = '0;
  logic [CNT_W-1:0]  phase_in = '0;
  logic [CODE_W-1:0] err_code = '0;
  logic [CODE_W-1:0] cs_code = '0;
  logic [CODE_W-1:0] ads_code = '0;
  logic [DT_W-1:0]   dt_ab_base = '0;
  logic [DT_W-1:0]   dt_cd_base = '0;
  logic dt_bypass = 1'b0;
  logic force_off = 1'b0;
  logic gate_a, gate_b, gate_c, gate_d;

  always #10 clk = ~clk;

  psfb_pwm i_psfb_pwm (
    .clk(clk), .rst(rst), .period_in(period_in), .phase_in(phase_in),
    .err_code(err_code), .cs_code(cs_code), .ads_code(ads_code),
    .dt_ab_base(dt_ab_base), .dt_cd_base(dt_cd_base), .dt_bypass(dt_bypass),
    .force_off(force_off), .gate_a(gate_a), .gate_b(gate_b),
    .gate_c(gate_c), .gate_d(gate_d)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_ramp, m_per, m_ph;
  int m_side [2];
  int m_dtc [2];
  int m_dtv [2];
  int m_run;
  logic [3:0] m_exp;

  // R5 dead-time rule
  function automatic int dt_expect(int base, int cs, int ads, bit byp);
    int d;
    if (byp) return 0;
    d = (cs > ads) ? cs - ads : 0;
    if (d > PEAK) d = PEAK;
    return (base * PEAK) / (PEAK + 3 * d);
  endfunction

  task automatic model_reset();
    m_ramp = 0; m_per = RST_PERIOD; m_ph = RST_PHASE; m_run = 0;
    for (int i = 0; i < 2; i++) begin
      m_side[i] = 0; m_dtc[i] = 0; m_dtv[i] = 0;
    end
    m_exp = 4'b0000;
  endtask

  task automatic model_step();
    bit tk, hit, en;
    bit fl [2];
    int phe, nrun;
    int bases [2];
    if (rst) begin
      model_reset();
      return;
    end
    tk  = (m_ramp == m_per);
    phe = (m_ph > m_per) ? m_per : m_ph;
    hit = (m_ramp == phe);
    nrun = m_run ? ((int'(err_code) < NL_OFF) ? 0 : 1) : ((int'(err_code) > NL_ON) ? 1 : 0);
    en = (!force_off) && (nrun == 1);
    fl[0] = tk; fl[1] = hit;
    bases[0] = int'(dt_ab_base); bases[1] = int'(dt_cd_base);
    for (int i = 0; i < 2; i++) begin
      if (fl[i]) begin
        m_side[i] = 1 - m_side[i];
        m_dtc[i]  = m_dtv[i];
      end else if (m_dtc[i] > 0) begin
        m_dtc[i]--;
      end
      m_exp[3 - 2*i] = en && (m_side[i] == 1) && (m_dtc[i] == 0);
      m_exp[2 - 2*i] = en && (m_side[i] == 0) && (m_dtc[i] == 0);
      m_dtv[i] = dt_expect(bases[i], int'(cs_code), int'(ads_code), dt_bypass);
    end
    if (tk) begin
      m_ramp = 0; m_per = int'(period_in); m_ph = int'(phase_in);
    end else begin
      m_ramp++;
    end
    m_run = nrun;
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates abcd actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs are set just after a negedge; one call covers one clock
  task automatic step(string tag);
    model_step();
    @(negedge clk);
    check(tag, {gate_a, gate_b, gate_c, gate_d}, m_exp);
  endtask

  task automatic run(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic measure_gap(int want, string tag);
    int cnt = 0;
    int guard = 0;
    while (!gate_a && guard < 400) begin step(tag); guard++; end
    while (gate_a && guard < 400) begin step(tag); guard++; end
    while (!gate_b && guard < 400) begin cnt++; step(tag); guard++; end
    checks++;
    if (cnt != want) begin
      errors++;
      $display("FAIL %s: A-to-B gap actual %0d expected %0d", tag, cnt, want);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    model_reset();
    @(negedge clk);
    rst = 1'b1;
    period_in = 10'd39; phase_in = 10'd20; err_code = 8'd0;
    dt_ab_base = 8'd8; dt_cd_base = 8'd4;
    run(4, "R1 reset");
    rst = 1'b0;
    run(120, "R1 idle until no-load on");

    // R9 hysteresis
    err_code = 8'd70; run(60, "R9 inside band stays off");
    err_code = 8'd78; run(100, "R9 above on");
    err_code = 8'd64; run(100, "R9 at off threshold stays on");
    err_code = 8'd63; run(60, "R9 below off");
    err_code = 8'd77; run(60, "R9 at on threshold stays off");
    err_code = 8'd200; run(40, "R9 back on");

    // R2 period change mid-cycle, R3 phase positions
    period_in = 10'd29; run(15, "R2 period held until tick");
    run(150, "R2 new period");
    phase_in = 10'd5; run(10, "R3 phase held until tick");
    run(150, "R3 early phase");
    phase_in = 10'd29; run(150, "R3 phase equals period");
    phase_in = 10'd400; run(150, "R3 phase clamped to period");
    phase_in = 10'd0; run(150, "R3 phase zero");

    // R5 modulation, R4 gap measured on leg A/B
    period_in = 10'd79; phase_in = 10'd40;
    dt_ab_base = 8'd40; dt_cd_base = 8'd20; ads_code = 8'd0;
    cs_code = 8'd0;   run(200, "R5 light load");
    measure_gap(40, "R4 gap at zero load");
    cs_code = 8'd128; run(200, "R5 peak load");
    measure_gap(10, "R5 four to one at peak");
    cs_code = 8'd64;  run(200, "R5 half load");
    measure_gap(16, "R5 half load gap");
    cs_code = 8'd250; run(200, "R5 saturated above peak");

    // R6 equal or larger offset
    cs_code = 8'd100; ads_code = 8'd100; run(200, "R6 ads equals cs");
    measure_gap(40, "R6 unmodulated gap");
    ads_code = 8'd150; run(200, "R6 ads above cs");

    // R7 bypass
    dt_bypass = 1'b1; run(200, "R7 bypass");
    measure_gap(0, "R7 zero gap");
    dt_bypass = 1'b0; ads_code = 8'd0;

    // R8 load code changes inside an interval
    for (int k = 0; k < 1500; k++) begin
      cs_code = 8'($urandom_range(0, 255));
      if (k % 7 == 0) dt_ab_base = 8'($urandom_range(5, 60));
      step("R8 sampled once per edge");
    end

    // R10 force-off pulses
    cs_code = 8'd30;
    for (int k = 0; k < 1500; k++) begin
      force_off = ($urandom_range(0, 9) == 0);
      step("R10 force off");
    end
    force_off = 1'b0;

    // R4 mixed random run
    for (int k = 0; k < 12000; k++) begin
      if (k % 97 == 0) period_in = 10'($urandom_range(30, 90));
      if (k % 53 == 0) phase_in = 10'($urandom_range(0, 100));
      if (k % 11 == 0) cs_code = 8'($urandom_range(0, 255));
      if (k % 13 == 0) ads_code = 8'($urandom_range(0, 140));
      if (k % 89 == 0) dt_ab_base = 8'($urandom_range(0, 28));
      if (k % 83 == 0) dt_cd_base = 8'($urandom_range(0, 28));
      if (k % 401 == 0) dt_bypass = ($urandom_range(0, 3) == 0);
      if (k % 17 == 0) err_code = 8'($urandom_range(55, 90));
      force_off = ($urandom_range(0, 30) == 0);
      step("R4 mixed random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule